// File: doc/BRIEF.md
# Serial Debug Port Shift Interface

This block connects an external development tool to a CPU through one full-duplex serial shift channel. Each frame the tool sends is a logic-high start bit followed by 34 bits. These are a mode bit, a control bit and a 32-bit payload, sent most significant first and sampled on the rising clock edge. While the frame comes in, the port sends back a 2-bit status code and a 32-bit word in the same bit periods. Between frames the serial output is the ready line, and a low level there means the port will accept the next frame.

In debug mode the port decides when every transfer happens. Ready goes low only when the CPU asks to read its next instruction or data word. A CPU write of outgoing data only queues that word for the next frame. A frame that arrives before ready is a sequencing error. It is dropped, and it is reported in the status of the following frame. Outside debug mode, ready returns at the end of every frame. Full 32-bit frames are refused there, and only short control words are accepted.

Top module: `dbg_serial_port`

## Requirements
- R1: After reset the serial output is low (ready) and none of the three delivery pulses is high.
- R2: A frame begins when the serial input is high on a rising edge while the port is idle. It then takes exactly 34 further bits in the order mode, control, payload[31] down to payload[0], one bit per clock.
- R3: A debug-mode frame with mode=0 is delivered in the cycle after its last bit. With control=0 the payload goes to `instr_word` with a one-cycle `instr_vld`, and with control=1 it goes to `data_word` with a one-cycle `data_vld`.
- R4: A frame with mode=1 delivers a 5-bit command with a one-cycle `ctl_vld`. The command is taken from payload bits 29 down to 25, which are payload positions 2 to 6 counted from the first payload bit sent.
- R5: In debug mode the idle serial output goes low in the cycle after a `cpu_rd_req` pulse. It goes high from the start of a frame and stays high until the next read request.
- R6: A `cpu_wr` pulse never brings ready low. The written word goes out in the next frame that starts after the write. A write made in the same cycle as a start bit goes out in the frame after that one.
- R7: The outgoing stream of a frame is status[1], status[0], then a 32-bit word, MSB first. Status 00 carries CPU data, 01 a sequencing error, 10 a pending CPU interrupt and 11 null. When several apply, the order is sequencing error, then data, then interrupt.
- R8: For every status other than 00, the outgoing word has bit 31 equal to the debug-mode input (freeze), bit 30 equal to the inverse of `dl_busy`, and bits 29 to 0 all ones.
- R9: A frame that starts while ready is not signalled is discarded with no delivery pulse. The next frame carries status 01, and the word received in that next frame is discarded as well.
- R10: Outside debug mode ready comes back at the end of every frame. A frame with mode=0 is discarded there and causes status 01 in the following frame, while mode=1 frames are delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock; serial input sampled on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_mode | input | 1 | CPU is in debug mode (freeze) |
| dl_busy | input | 1 | Download procedure in progress |
| cpu_irq | input | 1 | CPU interrupt pending, reported as status 10 |
| sdi | input | 1 | Serial input from the tool |
| sdo | output | 1 | Serial output: status/data during a frame, ready (low) between frames |
| cpu_rd_req | input | 1 | CPU requests its next instruction or data word |
| cpu_wr | input | 1 | CPU writes a word to be shifted out |
| cpu_wdata | input | 32 | Word written by the CPU |
| instr_word | output | 32 | Last delivered instruction |
| instr_vld | output | 1 | One-cycle pulse: new instruction |
| data_word | output | 32 | Last delivered data word |
| data_vld | output | 1 | One-cycle pulse: new data word |
| ctl_cmd | output | 5 | Last delivered control command |
| ctl_vld | output | 1 | One-cycle pulse: new control command |

## Verification
Two pairs of events can land on one clock edge. A CPU write can coincide with the start bit of a frame, and a read request can coincide with it too. The bench raises `cpu_wr` in the same cycle as the start bit. It then expects that frame to carry a null status word, and the written word to appear with status 00 only in the frame after. A second scenario sets up a pending sequencing error and pending CPU data together. The error must win one frame, and the data must follow intact in the next.

// File: rtl/dbgp_pkg.sv
package dbgp_pkg;

  typedef enum logic [1:0] {
    ST_DATA = 2'b00,
    ST_SEQ  = 2'b01,
    ST_IRQ  = 2'b10,
    ST_NULL = 2'b11
  } dbgp_status_e;

  // Priority: sequencing error, then queued CPU data, then interrupt, else null.
  function automatic dbgp_status_e pick_status(input logic seq_pend,
                                               input logic data_pend,
                                               input logic irq);
    if (seq_pend)       pick_status = ST_SEQ;
    else if (data_pend) pick_status = ST_DATA;
    else if (irq)       pick_status = ST_IRQ;
    else                pick_status = ST_NULL;
  endfunction

endpackage

// File: rtl/dbgp_rx.sv
module dbgp_rx #(
  parameter int unsigned PAY_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sdi,
  output logic               busy,
  output logic               start_evt,
  output logic               done_evt,
  output logic [PAY_W+1:0]   frame_o
);
  localparam int unsigned FR_W = PAY_W + 2;
  localparam int unsigned CW   = $clog2(FR_W + 1);

  logic [CW-1:0]   cnt;
  logic [FR_W-1:0] sr;

  assign start_evt = !busy && sdi;
  assign done_evt  = busy && (cnt == CW'(FR_W - 1));
  assign frame_o   = {sr[FR_W-2:0], sdi};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      sr   <= '0;
    end else if (start_evt) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      sr  <= frame_o;
      cnt <= cnt + 1'b1;
      if (done_evt) busy <= 1'b0;
    end
  end

  // R2
  start_opens_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (busy && cnt == '0));
  // R2
  frame_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> !busy);

endmodule

// File: rtl/dbgp_pace.sv
module dbgp_pace (
  input  logic clk,
  input  logic rst_n,
  input  logic dbg_mode,
  input  logic cpu_rd,
  input  logic start_evt,
  input  logic done_evt,
  input  logic short_frame,
  output logic rdy,
  output logic seq_pend,
  output logic deliver
);
  logic early_q;
  logic disc_q;
  logic refused;
  logic early_now;
  logic rdy_set;

  assign early_now = start_evt && !rdy;
  assign refused   = !dbg_mode && !short_frame;
  assign deliver   = done_evt && !disc_q && !refused;
  assign rdy_set   = (dbg_mode && cpu_rd) || (!dbg_mode && done_evt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy      <= 1'b1;
      seq_pend <= 1'b0;
      early_q  <= 1'b0;
      disc_q   <= 1'b0;
    end else begin
      rdy <= rdy_set || (rdy && !start_evt);
      if (start_evt) begin
        early_q  <= early_now;
        disc_q   <= early_now || seq_pend;
        seq_pend <= 1'b0;
      end else if (done_evt && (early_q || (refused && !disc_q))) begin
        seq_pend <= 1'b1;
      end
    end
  end

  // R10
  normal_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && !dbg_mode) |=> rdy);
  // R6
  no_ready_without_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_mode && !rdy && !cpu_rd && !done_evt) |=> !rdy);
  // R9
  early_flags_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && early_q) |=> seq_pend);

endmodule

// File: rtl/dbgp_tx.sv
module dbgp_tx
  import dbgp_pkg::*;
#(
  parameter int unsigned PAY_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_evt,
  input  logic             busy,
  input  logic             rdy,
  input  logic             seq_pend,
  input  logic             dbg_mode,
  input  logic             dl_busy,
  input  logic             cpu_irq,
  input  logic             cpu_wr,
  input  logic [PAY_W-1:0] cpu_wdata,
  output logic             sdo
);
  localparam int unsigned SW = PAY_W + 2;

  // Word sent with any non-data status: freeze, inverted download busy, ones.
  function automatic logic [PAY_W-1:0] idle_word(input logic frz, input logic dlb);
    idle_word          = '1;
    idle_word[PAY_W-1] = frz;
    idle_word[PAY_W-2] = !dlb;
  endfunction

  logic             tx_valid;
  logic [PAY_W-1:0] tx_data;
  logic [SW-1:0]    sr;
  dbgp_status_e     st_now;
  dbgp_status_e     st_q;
  logic [PAY_W-1:0] word_now;
  logic             consume;

  assign st_now   = pick_status(seq_pend, tx_valid, cpu_irq);
  assign word_now = (st_now == ST_DATA) ? tx_data : idle_word(dbg_mode, dl_busy);
  assign consume  = start_evt && (st_now == ST_DATA);
  assign sdo      = busy ? sr[SW-1] : !rdy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
      sr       <= '1;
      st_q     <= ST_NULL;
    end else begin
      tx_valid <= (tx_valid && !consume) || cpu_wr;
      if (cpu_wr) tx_data <= cpu_wdata;
      if (start_evt) begin
        sr   <= {st_now, word_now};
        st_q <= st_now;
      end else if (busy) begin
        sr <= {sr[SW-2:0], 1'b1};
      end
    end
  end

  // R7
  seq_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && seq_pend) |=> (st_q == ST_SEQ));
  // R6
  data_drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && !seq_pend && tx_valid && !cpu_wr) |=> (!tx_valid && st_q == ST_DATA));

endmodule

// File: rtl/dbg_serial_port.sv
module dbg_serial_port #(
  parameter int unsigned PAY_W = 32,
  parameter int unsigned CMD_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dbg_mode,
  input  logic             dl_busy,
  input  logic             cpu_irq,
  input  logic             sdi,
  output logic             sdo,
  input  logic             cpu_rd_req,
  input  logic             cpu_wr,
  input  logic [PAY_W-1:0] cpu_wdata,
  output logic [PAY_W-1:0] instr_word,
  output logic             instr_vld,
  output logic [PAY_W-1:0] data_word,
  output logic             data_vld,
  output logic [CMD_W-1:0] ctl_cmd,
  output logic             ctl_vld
);
  localparam int unsigned FR_W    = PAY_W + 2;
  localparam int unsigned CMD_TOP = PAY_W - 3;

  logic             busy, start_evt, done_evt;
  logic [FR_W-1:0]  frame;
  logic             mode_bit, ctrl_bit;
  logic [PAY_W-1:0] payload;
  logic             rdy, seq_pend, deliver;

  assign mode_bit = frame[FR_W-1];
  assign ctrl_bit = frame[FR_W-2];
  assign payload  = frame[PAY_W-1:0];

  dbgp_rx #(.PAY_W(PAY_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .sdi(sdi), .busy(busy),
    .start_evt(start_evt), .done_evt(done_evt), .frame_o(frame)
  );

  dbgp_pace u_pace (
    .clk(clk), .rst_n(rst_n), .dbg_mode(dbg_mode), .cpu_rd(cpu_rd_req),
    .start_evt(start_evt), .done_evt(done_evt), .short_frame(mode_bit),
    .rdy(rdy), .seq_pend(seq_pend), .deliver(deliver)
  );

  dbgp_tx #(.PAY_W(PAY_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .busy(busy), .rdy(rdy),
    .seq_pend(seq_pend), .dbg_mode(dbg_mode), .dl_busy(dl_busy),
    .cpu_irq(cpu_irq), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .sdo(sdo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      instr_word <= '0;
      data_word  <= '0;
      ctl_cmd    <= '0;
      instr_vld  <= 1'b0;
      data_vld   <= 1'b0;
      ctl_vld    <= 1'b0;
    end else begin
      instr_vld <= 1'b0;
      data_vld  <= 1'b0;
      ctl_vld   <= 1'b0;
      if (deliver) begin
        if (mode_bit) begin
          ctl_cmd <= payload[CMD_TOP -: CMD_W];
          ctl_vld <= 1'b1;
        end else if (ctrl_bit) begin
          data_word <= payload;
          data_vld  <= 1'b1;
        end else begin
          instr_word <= payload;
          instr_vld  <= 1'b1;
        end
      end
    end
  end

  // R3
  one_delivery_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({instr_vld, data_vld, ctl_vld}));
  // R3
  pulse_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_vld || data_vld || ctl_vld) |-> $past(done_evt));
  // R5
  busy_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && !cpu_rd_req && dbg_mode) |=> ##1 (busy || sdo));

endmodule

// File: tb/dbg_serial_port_test.sv
module dbg_serial_port_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dbg_mode = 1'b0, dl_busy = 1'b0, cpu_irq = 1'b0, sdi = 1'b0;
  logic        cpu_rd_req = 1'b0, cpu_wr = 1'b0;
  logic [31:0] cpu_wdata = '0;
  logic        sdo;
  logic [31:0] instr_word, data_word;
  logic        instr_vld, data_vld, ctl_vld;
  logic [4:0]  ctl_cmd;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_serial_port uut (
    .clk(clk), .rst_n(rst_n), .dbg_mode(dbg_mode), .dl_busy(dl_busy),
    .cpu_irq(cpu_irq), .sdi(sdi), .sdo(sdo), .cpu_rd_req(cpu_rd_req),
    .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .instr_word(instr_word),
    .instr_vld(instr_vld), .data_word(data_word), .data_vld(data_vld),
    .ctl_cmd(ctl_cmd), .ctl_vld(ctl_vld)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] nd_word(input logic frz, input logic dlb);
    return {frz, ~dlb, 30'h3FFF_FFFF};
  endfunction

  logic [33:0] got;
  logic        iv, dv, cv;

  task automatic do_frame(input logic mode, input logic ctrl, input logic [31:0] pay,
                          input logic wr_at_start, input logic [31:0] wdat);
    logic [34:0] f;
    f = {1'b1, mode, ctrl, pay};
    @(negedge clk);
    sdi = 1'b1;
    if (wr_at_start) begin cpu_wr = 1'b1; cpu_wdata = wdat; end
    for (int j = 1; j < 35; j++) begin
      @(negedge clk);
      cpu_wr = 1'b0;
      sdi = f[34-j];
      got[34-j] = sdo;
    end
    @(negedge clk);
    sdi = 1'b0;
    iv = instr_vld; dv = data_vld; cv = ctl_vld;
  endtask

  task automatic pulse_rd();
    @(negedge clk); cpu_rd_req = 1'b1;
    @(negedge clk); cpu_rd_req = 1'b0;
  endtask

  task automatic pulse_wr(input logic [31:0] d);
    @(negedge clk); cpu_wr = 1'b1; cpu_wdata = d;
    @(negedge clk); cpu_wr = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 sdo ready low", 64'(sdo), 64'd0);
    chk("R1 no pulses", 64'({instr_vld, data_vld, ctl_vld}), 64'd0);
  endtask

  task automatic t_normal();
    logic [31:0] p;
    p = 32'hA5F0_0000;
    do_frame(1'b1, 1'b0, p, 1'b0, '0);
    chk("R4 ctl pulse", 64'(cv), 64'd1);
    chk("R4 cmd field", 64'(ctl_cmd), 64'((p >> 25) & 32'h1F));
    chk("R7 null status", 64'(got[33:32]), 64'd3);
    chk("R8 idle word normal", 64'(got[31:0]), 64'(nd_word(1'b0, 1'b0)));
    chk("R10 ready after frame", 64'(sdo), 64'd0);
    do_frame(1'b0, 1'b0, 32'h0BAD_0BAD, 1'b0, '0);
    chk("R10 full frame refused", 64'({iv, dv, cv}), 64'd0);
    do_frame(1'b1, 1'b0, 32'hFFFF_FFFF, 1'b0, '0);
    chk("R10 seq status", 64'(got[33:32]), 64'd1);
    chk("R9 seq frame dropped", 64'(cv), 64'd0);
    do_frame(1'b1, 1'b0, 32'h0200_0000, 1'b0, '0);
    chk("R10 back to null", 64'(got[33:32]), 64'd3);
    chk("R4 cmd value", 64'({cv, ctl_cmd}), 64'({1'b1, 5'd1}));
  endtask

  task automatic t_debug();
    @(negedge clk); dbg_mode = 1'b1;
    do_frame(1'b0, 1'b0, 32'h1234_5678, 1'b0, '0);
    chk("R3 instr pulse", 64'({iv, dv, cv}), 64'b100);
    chk("R3 instr word", 64'(instr_word), 64'h1234_5678);
    chk("R8 freeze word", 64'(got[31:0]), 64'(nd_word(1'b1, 1'b0)));
    chk("R5 line high after frame", 64'(sdo), 64'd1);
    pulse_wr(32'hDEAD_BEEF);
    chk("R6 write no ready", 64'(sdo), 64'd1);
    pulse_rd();
    chk("R5 ready after read", 64'(sdo), 64'd0);
    do_frame(1'b0, 1'b1, 32'hCAFE_0001, 1'b0, '0);
    chk("R7 data status", 64'(got[33:32]), 64'd0);
    chk("R6 data out", 64'(got[31:0]), 64'hDEAD_BEEF);
    chk("R3 data pulse", 64'({iv, dv, cv}), 64'b010);
    chk("R3 data word", 64'(data_word), 64'hCAFE_0001);
  endtask

  task automatic t_irq();
    cpu_irq = 1'b1; dl_busy = 1'b1;
    pulse_rd();
    do_frame(1'b1, 1'b0, 32'h0000_0000, 1'b0, '0);
    chk("R7 irq status", 64'(got[33:32]), 64'd2);
    chk("R8 download bit", 64'(got[31:0]), 64'(nd_word(1'b1, 1'b1)));
    cpu_irq = 1'b0; dl_busy = 1'b0;
  endtask

  task automatic t_early();
    do_frame(1'b0, 1'b0, 32'h0000_1111, 1'b0, '0);
    chk("R9 early dropped", 64'({iv, dv, cv}), 64'd0);
    chk("R9 early status null", 64'(got[33:32]), 64'd3);
    pulse_wr(32'h5555_AAAA);
    pulse_rd();
    do_frame(1'b0, 1'b0, 32'h0000_2222, 1'b0, '0);
    chk("R7 seq beats data", 64'(got[33:32]), 64'd1);
    chk("R9 seq-out frame dropped", 64'({iv, dv, cv}), 64'd0);
    pulse_rd();
    do_frame(1'b0, 1'b0, 32'h0000_3333, 1'b0, '0);
    chk("R7 data after seq", 64'({got[33:32], got[31:0]}), 64'({2'b00, 32'h5555_AAAA}));
    chk("R9 recovered", 64'({iv, instr_word}), 64'({1'b1, 32'h0000_3333}));
  endtask

  task automatic t_collide();
    pulse_rd();
    do_frame(1'b1, 1'b0, 32'h0, 1'b1, 32'h0F0F_F0F0);
    chk("R6 same-cycle write not in frame", 64'(got), 64'({2'b11, nd_word(1'b1, 1'b0)}));
    pulse_rd();
    do_frame(1'b1, 1'b0, 32'h0, 1'b0, '0);
    chk("R6 same-cycle write next frame", 64'(got), 64'({2'b00, 32'h0F0F_F0F0}));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_normal();
    t_debug();
    t_irq();
    t_early();
    t_collide();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule